// File: doc/BRIEF.md
# Three-Lane Line Strip Divider

This block accepts a raster stream of pixels, one line after another, and cuts every line into three contiguous vertical strips. Each strip leaves on its own output lane. A compressor placed on a lane therefore sees an image one third as wide as the source, with no bound on its length. The divider never expects an end of frame. It keeps cycling through the lanes for as long as pixels arrive.

Each input pixel carries a valid strobe and a line-start marker. Within a line, the first segment goes to lane 0, the middle segment to lane 1, and the final segment to lane 2. The next line then starts again on lane 0. The three segment lengths are build-time parameters, and the line width is their sum. The default split is 1667, 1667 and 1666 pixels of 12 bits, which gives a 5000-pixel line.

Each lane has its own pixel register, valid strobe, strip-start flag and strip-end flag. A line-start marker that arrives anywhere other than at the first pixel of a line forces the position back to the start of lane 0. It also raises a sticky line-length error flag.

Top module: `strip_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every lane valid, strip-start and strip-end output is low, and the line-length error flag is low.
- R2: An accepted pixel appears exactly one clock later on one lane, with its value unchanged. Lane k carries its pixel in bits [k*PIX_W +: PIX_W] of the pixel bus.
- R3: Line positions 0 to SEG0-1 go to lane 0, positions SEG0 to SEG0+SEG1-1 go to lane 1, and the remaining SEG2 positions go to lane 2. Lane k drives bit k of each lane vector.
- R4: The lane strip-start flag is high only with the first pixel of that lane's segment. The lane strip-end flag is high only with the last pixel of that segment.
- R5: No more than one lane valid bit is high in any cycle.
- R6: After the last pixel of lane 2, the next accepted pixel goes to lane 0 as a new line, whether or not a line-start marker comes with it.
- R7: A pixel accepted with the line-start marker high is always routed to lane 0 as the first pixel of a line.
- R8: A line-start marker on an accepted pixel that is not at line position 0 sets the error flag, and the flag then stays high until reset. A marker at position 0 leaves the flag unchanged.
- R9: A cycle with the input valid low produces no valid output on any lane and does not advance the line position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | Input line-start marker, qualified by in_valid |
| in_pix | input | PIX_W | Input pixel value |
| lane_vld | output | 3 | Per-lane output valid, bit k for lane k |
| lane_sol | output | 3 | Per-lane strip-start flag |
| lane_eol | output | 3 | Per-lane strip-end flag |
| lane_pix | output | 3*PIX_W | Per-lane pixel registers, lane k in slice k |
| len_err | output | 1 | Sticky line-length error flag |

## Verification
The bench builds the divider with 12-bit pixels and segments of 5, 5 and 4, so each line is 14 pixels long. With these short segments, a few thousand cycles cover hundreds of line wraps, including the uneven final segment and every segment boundary. They also cover many early and on-time line markers and a wide mix of idle gaps, none of which a 5000-pixel line could reach in a short run.

// File: rtl/strip_divider.sv
module strip_divider #(
  parameter int PIX_W = 12,
  parameter int SEG0  = 1667,
  parameter int SEG1  = 1667,
  parameter int SEG2  = 1666
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sol,
  input  logic [PIX_W-1:0]     in_pix,
  output logic [2:0]           lane_vld,
  output logic [2:0]           lane_sol,
  output logic [2:0]           lane_eol,
  output logic [3*PIX_W-1:0]   lane_pix,
  output logic                 len_err
);
  localparam int SEG_MAX = (SEG0 > SEG1) ? ((SEG0 > SEG2) ? SEG0 : SEG2)
                                         : ((SEG1 > SEG2) ? SEG1 : SEG2);
  localparam int CNT_W   = $clog2(SEG_MAX + 1);
  localparam logic [CNT_W-1:0] LAST0 = CNT_W'(SEG0 - 1);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(SEG1 - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(SEG2 - 1);

  logic [1:0]       lane_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       cur_lane;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] cur_last;
  logic [2:0]       cur_hot;
  logic             seg_end;
  logic             at_origin;

  assign at_origin = (lane_q == 2'd0) && (cnt_q == '0);
  assign cur_lane  = in_sol ? 2'd0 : lane_q;
  assign cur_cnt   = in_sol ? '0   : cnt_q;
  assign seg_end   = (cur_cnt == cur_last);
  assign cur_hot   = 3'b001 << cur_lane;

  always_comb begin
    case (cur_lane)
      2'd0:    cur_last = LAST0;
      2'd1:    cur_last = LAST1;
      default: cur_last = LAST2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q   <= 2'd0;
      cnt_q    <= '0;
      lane_vld <= '0;
      lane_sol <= '0;
      lane_eol <= '0;
      len_err  <= 1'b0;
    end else begin
      lane_vld <= in_valid ? cur_hot : 3'b000;
      lane_sol <= (in_valid && cur_cnt == '0) ? cur_hot : 3'b000;
      lane_eol <= (in_valid && seg_end) ? cur_hot : 3'b000;
      if (in_valid) begin
        if (in_sol && !at_origin) len_err <= 1'b1;
        if (seg_end) begin
          cnt_q  <= '0;
          lane_q <= (cur_lane == 2'd2) ? 2'd0 : cur_lane + 2'd1;
        end else begin
          cnt_q  <= cur_cnt + 1'b1;
          lane_q <= cur_lane;
        end
      end
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_pix[k*PIX_W +: PIX_W] <= '0;
      else if (in_valid && cur_hot[k])
        lane_pix[k*PIX_W +: PIX_W] <= in_pix;
    end
  end
endmodule

// File: rtl/strip_divider_chk.sv
module strip_divider_chk #(
  parameter int PIX_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_sol,
  input logic [PIX_W-1:0]   in_pix,
  input logic [2:0]         lane_vld,
  input logic [2:0]         lane_sol,
  input logic [2:0]         lane_eol,
  input logic [3*PIX_W-1:0] lane_pix,
  input logic               len_err
);
  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_vld));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid)) |-> (lane_vld != 3'b000));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> (lane_vld == 3'b000));

  assert_sol_lane0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(in_sol)) |-> (lane_vld[0] && lane_sol[0]));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

  assert_flags_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_sol | lane_eol) & ~lane_vld) == 3'b000);

  for (genvar k = 0; k < 3; k++) begin : g_pix
    assert_pix_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && lane_vld[k]) |-> (lane_pix[k*PIX_W +: PIX_W] == $past(in_pix)));
  end
endmodule

bind strip_divider strip_divider_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
  .in_pix(in_pix), .lane_vld(lane_vld), .lane_sol(lane_sol),
  .lane_eol(lane_eol), .lane_pix(lane_pix), .len_err(len_err)
);

// File: tb/strip_divider_tb.sv
module strip_divider_tb;
  localparam int W  = 12;
  localparam int S0 = 5;
  localparam int S1 = 5;
  localparam int S2 = 4;
  localparam int LW = S0 + S1 + S2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_sol = 1'b0;
  logic [W-1:0]   in_pix = '0;
  logic [2:0]     lane_vld, lane_sol, lane_eol;
  logic [3*W-1:0] lane_pix;
  logic           len_err;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit err_exp = 1'b0;

  strip_divider #(.PIX_W(W), .SEG0(S0), .SEG1(S1), .SEG2(S2)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_pix(in_pix), .lane_vld(lane_vld), .lane_sol(lane_sol),
    .lane_eol(lane_eol), .lane_pix(lane_pix), .len_err(len_err)
  );

  always #10 clk = ~clk;

  function automatic int lane_of(int p);
    if (p < S0) return 0;
    if (p < S0 + S1) return 1;
    return 2;
  endfunction

  function automatic int seg_start(int p);
    if (p < S0) return 0;
    if (p < S0 + S1) return S0;
    return S0 + S1;
  endfunction

  function automatic int seg_last(int p);
    if (p < S0) return S0 - 1;
    if (p < S0 + S1) return S0 + S1 - 1;
    return LW - 1;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_sol = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "vld in reset", lane_vld, 0);
    check("R1", "err in reset", len_err, 0);
    rst_n = 1'b1;
    pos = 0; err_exp = 1'b0;
    @(posedge clk); #1;
    check("R1", "vld after reset", lane_vld, 0);
    check("R1", "flags after reset", {lane_sol, lane_eol}, 0);
    check("R1", "err after reset", len_err, 0);
  endtask

  task automatic step(bit v, bit s, logic [W-1:0] p, string tag);
    int e_lane;
    bit e_sol, e_eol;
    @(negedge clk);
    in_valid = v; in_sol = s; in_pix = p;
    e_lane = -1; e_sol = 1'b0; e_eol = 1'b0;
    if (v) begin
      if (s) begin
        if (pos != 0) err_exp = 1'b1;
        pos = 0;
      end
      e_lane = lane_of(pos);
      e_sol  = (pos == seg_start(pos));
      e_eol  = (pos == seg_last(pos));
      pos    = (pos + 1) % LW;
    end
    @(posedge clk); #1;
    check("R5", "valid count", $countones(lane_vld) <= 1, 1);
    if (e_lane < 0) begin
      check("R9", "vld when idle", lane_vld, 0);
    end else begin
      check(tag, "lane select", lane_vld, 3'b001 << e_lane);
      check("R4", "strip start", lane_sol[e_lane], e_sol);
      check("R4", "strip end", lane_eol[e_lane], e_eol);
      check("R2", "pixel", lane_pix[e_lane*W +: W], p);
    end
    check("R8", "error flag", len_err, err_exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    for (int i = 0; i < LW; i++) step(1, i == 0, W'(i + 100), "R3");
    for (int i = 0; i < LW; i++) step(1, 0, W'(i + 300), "R6");
    for (int i = 0; i < LW; i++) begin
      step(1, 0, W'($urandom), "R6");
      step(0, 0, W'($urandom), "R9");
    end
    step(1, 1, 12'hABC, "R7");
    step(1, 0, 12'h123, "R3");
    step(1, 0, 12'h456, "R3");
    step(1, 1, 12'h789, "R7");
    step(0, 1, 12'h000, "R9");
    for (int i = 0; i < LW; i++) step(1, 0, W'($urandom), "R6");
    do_reset();
    for (int i = 0; i < S0 + S1 + 1; i++) step(1, 0, W'($urandom), "R3");
    step(1, 1, 12'hFFF, "R7");
    for (int i = 0; i < 3000; i++) begin
      bit v, s;
      v = ($urandom % 4) != 0;
      s = (pos == 0 && ($urandom % 2) == 1) || ($urandom % 300 == 0);
      step(v, s, W'($urandom), pos == 0 ? "R6" : "R3");
      if (i == 1500) do_reset();
    end
    summary();
  end
endmodule